// File: doc/BRIEF.md
# Threshold-Signalled Packet Output FIFO

This block is a single-clock packet buffer placed between a link receiver and a user sink. Each stored word holds a data field plus its sideband: start-of-packet and end-of-packet markers, a per-word error flag, a count of empty bytes, and a packet identifier. All of these are kept together in one memory entry. The receiver writes words with a write enable and sees a ready indication that reports free space. The sink uses a pull-style read port: it watches a data-available signal, raises a read enable, and gets the word with a valid strobe one clock later.

Data-available depends on two conditions. It goes high when the stored word count is above a programmable threshold. It is also forced high whenever at least one end-of-packet word is held. A short packet that never fills the buffer up to the threshold can therefore still be drained without waiting for more traffic. The buffer tracks how many end-of-packet words it holds, and the count stays exact when one such word is written and another is read in the same cycle.

Writes offered while the buffer is full are dropped and set a sticky overflow flag, which only reset clears. A read enable while the buffer is empty is ignored. Reset is synchronous and active high.

Top module: `pkt_out_fifo`

## Requirements
- R1: While reset is high and in the first cycle after it, rd_valid, rd_avail and overflow are 0 and wr_ready is 1.
- R2: wr_ready is 0 exactly when DEPTH words are stored. A write offered while wr_ready is 0 is dropped, and the word never appears at the read port.
- R3: A write offered while wr_ready is 0 sets overflow from the next cycle on. overflow then stays 1 until reset.
- R4: When rd_en is high and at least one word is stored, the oldest stored word appears on rd_data in the next cycle with rd_valid high. Words leave in the order they were written.
- R5: When rd_en is high and no word is stored, rd_valid is 0 in the next cycle and no stored word is consumed.
- R6: rd_avail is 1 whenever the stored word count is greater than THRESH.
- R7: rd_avail is 1 whenever at least one stored word has its end-of-packet bit set, whatever the count. When the count is at most THRESH and no end-of-packet word is stored, rd_avail is 0.
- R8: rd_sop, rd_eop, rd_mty and rd_id on a valid output word equal the values written with that word.
- R9: A write and a read accepted in the same cycle leave the stored count unchanged. The end-of-packet tracking counts both the word that enters and the word that leaves.
- R10: rd_err is reported per word. It is 1 only on the words written with wr_err set, and it is not extended to later words of the same packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write enable; the word is offered this cycle |
| wr_sop | input | 1 | Start-of-packet marker of the offered word |
| wr_eop | input | 1 | End-of-packet marker of the offered word |
| wr_err | input | 1 | Error flag of the offered word |
| wr_mty | input | MTY_W | Number of unused bytes in the offered word |
| wr_data | input | DATA_W | Data of the offered word |
| wr_id | input | ID_W | Packet identifier of the offered word |
| wr_ready | output | 1 | High while the buffer is not full |
| overflow | output | 1 | Sticky flag: a write was dropped |
| rd_avail | output | 1 | Count above THRESH, or an end-of-packet word stored |
| rd_en | input | 1 | Read request; the word follows one cycle later |
| rd_valid | output | 1 | Output word valid this cycle |
| rd_sop | output | 1 | Start-of-packet marker of the output word |
| rd_eop | output | 1 | End-of-packet marker of the output word |
| rd_err | output | 1 | Error flag of the output word |
| rd_mty | output | MTY_W | Unused byte count of the output word |
| rd_data | output | DATA_W | Data of the output word |
| rd_id | output | ID_W | Packet identifier; meaningful with rd_sop |

## Verification
Some invariants are checked by assertions on every cycle. The count never passes DEPTH. Overflow sets after a dropped write and stays set. A simultaneous write and read leaves the count unchanged. A read of an empty buffer neither consumes a word nor raises rd_valid. The end-of-packet tally never exceeds the stored count. Other properties need the bench's cycle-accurate queue model to show them: the order and sideband content of the words read out, per-word error reporting, and the exact moments rd_avail rises and falls across the threshold and around buffered packet ends.

// File: rtl/pkt_fifo_pkg.sv
package pkt_fifo_pkg;

   // Bit layout of one stored entry, from the lowest bit up:
   // data, id, empty-byte count, error, end, start.
   function automatic int unsigned id_lo(input int unsigned dw);
      return dw;
   endfunction

   function automatic int unsigned mty_lo(input int unsigned dw, input int unsigned iw);
      return dw + iw;
   endfunction

   function automatic int unsigned err_bit(input int unsigned dw, input int unsigned iw,
                                           input int unsigned mw);
      return dw + iw + mw;
   endfunction

   function automatic int unsigned entry_w(input int unsigned dw, input int unsigned iw,
                                           input int unsigned mw);
      return dw + iw + mw + 3;
   endfunction

endpackage

// File: rtl/pkt_fifo_store.sv
module pkt_fifo_store #(
   parameter int unsigned WIDTH = 41,
   parameter int unsigned DEPTH = 16,
   localparam int unsigned AW   = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             we,
   input  logic [AW-1:0]    waddr,
   input  logic [WIDTH-1:0] wdata,
   input  logic [AW-1:0]    raddr,
   output logic [WIDTH-1:0] rdata
);

   logic [WIDTH-1:0] ent [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_ent
      always_ff @(posedge clk) begin
         if (we && (waddr == AW'(g))) begin
            ent[g] <= wdata;
         end
      end
   end

   assign rdata = ent[raddr];

endmodule

// File: rtl/pkt_fifo_ctrl.sv
module pkt_fifo_ctrl #(
   parameter int unsigned DEPTH = 16,
   localparam int unsigned AW   = $clog2(DEPTH),
   localparam int unsigned CW   = AW + 1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          wr_en,
   input  logic          rd_en,
   output logic          wr_acc,
   output logic          rd_fire,
   output logic [AW-1:0] waddr,
   output logic [AW-1:0] raddr,
   output logic [CW-1:0] count,
   output logic          wr_ready,
   output logic          overflow
);

   localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

   logic empty;

   assign empty    = (count == '0);
   assign wr_ready = (count != FULL_CNT);
   assign wr_acc   = wr_en && wr_ready;
   assign rd_fire  = rd_en && !empty;

   always_ff @(posedge clk) begin
      if (rst) begin
         waddr    <= '0;
         raddr    <= '0;
         count    <= '0;
         overflow <= 1'b0;
      end else begin
         if (wr_acc)  waddr <= waddr + 1'b1;
         if (rd_fire) raddr <= raddr + 1'b1;
         case ({wr_acc, rd_fire})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
         if (wr_en && !wr_ready) overflow <= 1'b1;
      end
   end

   // R2: stored count never exceeds the depth
   a_r2_count_bound: assert property (@(posedge clk) disable iff (rst)
      count <= FULL_CNT);

   // R3: a refused write sets the flag, and the flag stays set
   a_r3_overflow_set: assert property (@(posedge clk) disable iff (rst)
      (wr_en && !wr_ready) |=> overflow);
   a_r3_overflow_sticky: assert property (@(posedge clk) disable iff (rst)
      overflow |=> overflow);

   // R5: reading an empty buffer consumes nothing
   a_r5_empty_read_holds: assert property (@(posedge clk) disable iff (rst)
      (rd_en && empty && !wr_en) |=> (count == '0));

   // R9: simultaneous write and read keep the count
   a_r9_count_hold: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_ready && rd_en && !empty) |=> $stable(count));

endmodule

// File: rtl/pkt_fifo_eop_track.sv
module pkt_fifo_eop_track #(
   parameter int unsigned DEPTH  = 16,
   parameter int unsigned THRESH = 8,
   localparam int unsigned AW    = $clog2(DEPTH),
   localparam int unsigned CW    = AW + 1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          push_eop,
   input  logic          pop_eop,
   input  logic [CW-1:0] count,
   output logic [CW-1:0] eop_cnt,
   output logic          rd_avail
);

   localparam logic [CW-1:0] THR = CW'(THRESH);

   always_ff @(posedge clk) begin
      if (rst) begin
         eop_cnt <= '0;
      end else begin
         case ({push_eop, pop_eop})
            2'b10:   eop_cnt <= eop_cnt + 1'b1;
            2'b01:   eop_cnt <= eop_cnt - 1'b1;
            default: eop_cnt <= eop_cnt;
         endcase
      end
   end

   assign rd_avail = (count > THR) || (eop_cnt != '0);

endmodule

// File: rtl/pkt_out_fifo.sv
module pkt_out_fifo
   import pkt_fifo_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned MTY_W  = 2,
   parameter int unsigned DEPTH  = 16,
   parameter int unsigned ID_W   = 4,
   parameter int unsigned THRESH = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic              wr_sop,
   input  logic              wr_eop,
   input  logic              wr_err,
   input  logic [MTY_W-1:0]  wr_mty,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ID_W-1:0]   wr_id,
   output logic              wr_ready,
   output logic              overflow,
   output logic              rd_avail,
   input  logic              rd_en,
   output logic              rd_valid,
   output logic              rd_sop,
   output logic              rd_eop,
   output logic              rd_err,
   output logic [MTY_W-1:0]  rd_mty,
   output logic [DATA_W-1:0] rd_data,
   output logic [ID_W-1:0]   rd_id
);

   localparam int unsigned AW     = $clog2(DEPTH);
   localparam int unsigned CW     = AW + 1;
   localparam int unsigned EW     = entry_w(DATA_W, ID_W, MTY_W);
   localparam int unsigned ID_LO  = id_lo(DATA_W);
   localparam int unsigned MTY_LO = mty_lo(DATA_W, ID_W);
   localparam int unsigned ERR_B  = err_bit(DATA_W, ID_W, MTY_W);
   localparam int unsigned EOP_B  = ERR_B + 1;
   localparam int unsigned SOP_B  = ERR_B + 2;

   initial begin
      a_prm_depth_pow2: assert (DEPTH >= 2 && DEPTH == (1 << AW))
         else $fatal(1, "DEPTH must be a power of two, at least 2");
      a_prm_thresh: assert (THRESH < DEPTH)
         else $fatal(1, "THRESH must be below DEPTH");
      a_prm_mty: assert (MTY_W >= 1 && DATA_W == (8 << MTY_W))
         else $fatal(1, "MTY_W must be log2 of the bytes per word");
      a_prm_id: assert (ID_W >= 1)
         else $fatal(1, "ID_W must be at least 1");
   end

   logic          wr_acc, rd_fire;
   logic [AW-1:0] waddr, raddr;
   logic [CW-1:0] count, eop_cnt;
   logic [EW-1:0] wword, rword, oword;

   assign wword = {wr_sop, wr_eop, wr_err, wr_mty, wr_id, wr_data};

   pkt_fifo_ctrl #(.DEPTH(DEPTH)) ctrl_i (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (wr_en),
      .rd_en    (rd_en),
      .wr_acc   (wr_acc),
      .rd_fire  (rd_fire),
      .waddr    (waddr),
      .raddr    (raddr),
      .count    (count),
      .wr_ready (wr_ready),
      .overflow (overflow)
   );

   pkt_fifo_store #(.WIDTH(EW), .DEPTH(DEPTH)) store_i (
      .clk   (clk),
      .we    (wr_acc),
      .waddr (waddr),
      .wdata (wword),
      .raddr (raddr),
      .rdata (rword)
   );

   pkt_fifo_eop_track #(.DEPTH(DEPTH), .THRESH(THRESH)) eop_i (
      .clk      (clk),
      .rst      (rst),
      .push_eop (wr_acc && wr_eop),
      .pop_eop  (rd_fire && rword[EOP_B]),
      .count    (count),
      .eop_cnt  (eop_cnt),
      .rd_avail (rd_avail)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         rd_valid <= 1'b0;
         oword    <= '0;
      end else begin
         rd_valid <= rd_fire;
         if (rd_fire) oword <= rword;
      end
   end

   assign rd_data = oword[DATA_W-1:0];
   assign rd_id   = oword[ID_LO +: ID_W];
   assign rd_mty  = oword[MTY_LO +: MTY_W];
   assign rd_err  = oword[ERR_B];
   assign rd_eop  = oword[EOP_B];
   assign rd_sop  = oword[SOP_B];

   // R4: a read of a non-empty buffer yields a valid word next cycle
   a_r4_valid_follows_read: assert property (@(posedge clk) disable iff (rst)
      (rd_en && count != '0) |=> rd_valid);

   // R7: the end-of-packet tally never exceeds the stored words
   a_r7_eop_le_count: assert property (@(posedge clk) disable iff (rst)
      eop_cnt <= count);

endmodule

// File: tb/pkt_out_fifo_tb_top.sv
module pkt_out_fifo_tb_top;

   localparam int DW = 32, MW = 2, DEPTH = 16, IW = 4, THR = 8;

   typedef struct {
      logic          sop, eop, err;
      logic [MW-1:0] mty;
      logic [DW-1:0] data;
      logic [IW-1:0] id;
   } word_t;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic          rst = 1'b1;
   logic          wr_en = 0, wr_sop = 0, wr_eop = 0, wr_err = 0, rd_en = 0;
   logic [MW-1:0] wr_mty = '0;
   logic [DW-1:0] wr_data = '0;
   logic [IW-1:0] wr_id = '0;
   logic          wr_ready, overflow, rd_avail, rd_valid, rd_sop, rd_eop, rd_err;
   logic [MW-1:0] rd_mty;
   logic [DW-1:0] rd_data;
   logic [IW-1:0] rd_id;

   pkt_out_fifo #(.DATA_W(DW), .MTY_W(MW), .DEPTH(DEPTH), .ID_W(IW), .THRESH(THR)) dut_i (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sop(wr_sop), .wr_eop(wr_eop),
      .wr_err(wr_err), .wr_mty(wr_mty), .wr_data(wr_data), .wr_id(wr_id),
      .wr_ready(wr_ready), .overflow(overflow), .rd_avail(rd_avail), .rd_en(rd_en),
      .rd_valid(rd_valid), .rd_sop(rd_sop), .rd_eop(rd_eop), .rd_err(rd_err),
      .rd_mty(rd_mty), .rd_data(rd_data), .rd_id(rd_id)
   );

   int    checks = 0, failures = 0;
   bit    done = 0;
   word_t q[$];
   word_t m_out;
   bit    m_valid = 0, m_ovf = 0, m_both = 0;
   int    wseq = 0;

   function automatic void chk(bit ok, string tag, longint act, longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
      end
   endfunction

   function automatic bit m_avail();
      if (q.size() > THR) return 1;
      foreach (q[i]) if (q[i].eop) return 1;
      return 0;
   endfunction

   function automatic bit m_has_eop();
      foreach (q[i]) if (q[i].eop) return 1;
      return 0;
   endfunction

   // reference model update at the active edge, from the inputs held since the last negedge
   task automatic model_edge();
      bit full, rf, wa;
      word_t w;
      if (rst) begin
         q.delete(); m_valid = 0; m_ovf = 0; m_both = 0;
         return;
      end
      full = (q.size() == DEPTH);
      rf   = rd_en && (q.size() > 0);
      wa   = wr_en && !full;
      if (wr_en && full) m_ovf = 1;
      m_both  = rf && wa;
      m_valid = rf;
      if (rf) m_out = q.pop_front();
      if (wa) begin
         w.sop = wr_sop; w.eop = wr_eop; w.err = wr_err;
         w.mty = wr_mty; w.data = wr_data; w.id = wr_id;
         q.push_back(w);
      end
   endtask

   task automatic compare();
      chk(wr_ready == (q.size() != DEPTH), "R2 wr_ready", wr_ready, q.size() != DEPTH);
      chk(overflow == m_ovf, "R3 overflow", overflow, m_ovf);
      if (q.size() > THR)
         chk(rd_avail == 1'b1, "R6 rd_avail above threshold", rd_avail, 1);
      else if (m_has_eop())
         chk(rd_avail == 1'b1, "R7 rd_avail with buffered end", rd_avail, 1);
      else
         chk(rd_avail == 1'b0, "R7 rd_avail idle", rd_avail, 0);
      if (m_valid) begin
         chk(rd_valid == 1'b1, m_both ? "R9 rd_valid on simultaneous access" : "R4 rd_valid",
             rd_valid, 1);
         chk(rd_data == m_out.data, "R4 rd_data order", rd_data, m_out.data);
         chk({rd_sop, rd_eop, rd_mty, rd_id} == {m_out.sop, m_out.eop, m_out.mty, m_out.id},
             "R8 sideband", {rd_sop, rd_eop, rd_mty, rd_id},
             {m_out.sop, m_out.eop, m_out.mty, m_out.id});
         chk(rd_err == m_out.err, "R10 rd_err", rd_err, m_out.err);
      end else begin
         chk(rd_valid == 1'b0, "R5 rd_valid idle", rd_valid, 0);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      model_edge();
      @(negedge clk);
      compare();
   endtask

   task automatic set_wr(bit en, bit sop, bit eop, bit err);
      wr_en = en; wr_sop = sop; wr_eop = eop; wr_err = err;
      wseq++;
      wr_data = 32'hA500_0000 + 32'(wseq * 7);
      wr_id   = IW'(wseq);
      wr_mty  = eop ? MW'(wseq) : '0;
   endtask

   task automatic idle();
      set_wr(0, 0, 0, 0); rd_en = 0;
   endtask

   task automatic do_reset();
      rst = 1; idle();
      tick(); tick();
      chk(!rd_valid && !rd_avail && !overflow && wr_ready, "R1 reset outputs",
          {rd_valid, rd_avail, overflow, wr_ready}, 4'b0001);
      rst = 0;
      tick();
      chk(!rd_valid && !rd_avail && !overflow && wr_ready, "R1 first cycle after reset",
          {rd_valid, rd_avail, overflow, wr_ready}, 4'b0001);
   endtask

   initial begin
      @(negedge clk);
      do_reset();

      // short packet below threshold: end marker makes data available (R7)
      set_wr(1, 1, 0, 0); tick();
      set_wr(1, 0, 0, 1); tick();
      set_wr(1, 0, 1, 0); tick();
      idle(); tick();
      chk(rd_avail == 1'b1, "R7 short packet available", rd_avail, 1);
      rd_en = 1; repeat (4) tick();
      // read while empty (R5)
      rd_en = 1; repeat (3) tick();
      idle(); tick();

      // fill with no end marker across the threshold (R6)
      for (int i = 0; i < THR + 2; i++) begin
         set_wr(1, i == 0, 0, i == 3); tick();
      end
      idle(); tick();
      chk(rd_avail == 1'b1, "R6 above threshold", rd_avail, 1);
      // drain down to the threshold: avail falls
      rd_en = 1; repeat (2) tick();
      rd_en = 0; tick();
      chk(rd_avail == 1'b0, "R7 at threshold without end", rd_avail, 0);

      // fill to full then overflow (R2, R3)
      for (int i = 0; i < DEPTH; i++) begin
         set_wr(1, 0, i == DEPTH - 1, 0); tick();
      end
      idle(); tick();
      chk(overflow == 1'b1, "R3 overflow set", overflow, 1);
      chk(wr_ready == 1'b0, "R2 full", wr_ready, 0);

      // simultaneous read and write while full: write refused, read proceeds
      set_wr(1, 1, 0, 0); rd_en = 1; tick();
      // streaming with both every cycle (R9)
      for (int i = 0; i < 20; i++) begin
         set_wr(1, (i % 5) == 0, (i % 5) == 4, (i % 7) == 2); rd_en = 1; tick();
      end
      idle(); rd_en = 1;
      repeat (DEPTH + 3) tick();
      idle(); tick();
      chk(overflow == 1'b1, "R3 overflow sticky", overflow, 1);

      // alternating patterns with gaps
      for (int i = 0; i < 40; i++) begin
         set_wr((i % 3) != 2, (i % 4) == 0, (i % 4) == 3, (i % 6) == 1);
         rd_en = (i % 2) == 1;
         tick();
      end
      idle(); rd_en = 1; repeat (DEPTH + 2) tick();

      // reset clears overflow (R1)
      do_reset();
      idle(); tick();

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; failures++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule